// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits between a host bus and a parallel NOR flash array. It watches bus writes and reads them as multi-cycle command sequences. A sequence starts with two address-qualified unlock writes and ends with a command byte. From these writes the block tracks the active command code and chooses what a read returns: array data, identification words, the query table or engine status. It also issues single-cycle start pulses to the program and erase engines. It latches the target address and data for those engines, and it waits for their completion signal before it accepts the next sequence.

Bus width is a parameter. A byte offset becomes a word address with a right shift of one for a 16-bit bus or two for a 32-bit bus, and only the low 11 bits of that word address are compared against the unlock addresses. In unlock-bypass mode each program needs only the command byte and the data write, with no unlock pair and no address check. A query sub-mode can be entered from read mode or from inside identification mode. When entered from identification mode, it remembers its origin.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, and after any reset pulse, cmdCode is 0x00, readMode is 0 (array), no start pulse is high and bypass mode is off. The readMode codes are 0 array, 1 identification, 2 query, 3 status.
- R2: A sequence begins with 0xAA written to word address 0x555 and continues with 0x55 written to word address 0x2AA. Any other write at either step returns the decoder to read-array mode with cmdCode 0x00.
- R3: The word address is the byte offset shifted right by log2(BUS_BYTES). Only its low 11 bits are compared, so byte offsets 0x1AAA and 0x1554 act as unlock addresses on a 16-bit bus.
- R4: After the unlock pair, 0x90 at word 0x555 selects identification (cmdCode 0x90, readMode 1). 0xA0 selects program (cmdCode 0xA0, readMode 3). The next write after 0xA0 raises progStart for exactly one cycle and presents its byte address on opAddr and its data on opData.
- R5: 0x80 followed by a second 0xAA/0x55 pair arms erase. Then 0x10 at word 0x555 raises chipEraseStart with cmdCode 0x10, and 0x30 at any address raises sectorEraseStart with that address on opAddr and cmdCode 0x30. A 0x10 at any other address resets the decoder.
- R6: While a program or erase is running, every write is ignored, 0xF0 included. engDone ends the operation and leads to read mode, or to the command cycle if bypass is on, with cmdCode 0x00.
- R7: 0x20 in the command cycle enters bypass. In bypass, 0xA0 at any address followed by a data write programs without an unlock pair. In bypass identification, writing 0x00 leaves bypass.
- R8: 0x98 at word 0x55 from read mode enters query mode (cmdCode 0x98, readMode 2). A 0x98 at any other address does not. Any write in query mode returns to read-array mode.
- R9: 0x98 at word 0x55 from identification mode enters the query sub-mode. 0xF0 there returns to identification (cmdCode 0x90). Any other write in identification mode resets the decoder.
- R10: 0xF0 resets the decoder from every state except running operations, the query sub-mode and the program data cycle. In the program data cycle 0xF0 is taken as the data to program.
- R11: A write that arrives in the same cycle as engDone during an operation is dropped. Completion takes effect and the write starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrData | input | 8 | Write data byte |
| engDone | input | 1 | Program or erase engine has finished |
| cmdCode | output | 8 | Active command code |
| readMode | output | 2 | Read source: 0 array, 1 ident, 2 query, 3 status |
| progStart | output | 1 | One-cycle program start |
| chipEraseStart | output | 1 | One-cycle chip erase start |
| sectorEraseStart | output | 1 | One-cycle sector erase start |
| opAddr | output | ADDR_W | Latched byte address for program or sector erase |
| opData | output | 8 | Latched program data |

## Verification
The engine completion and a bus write can land on the same clock edge while a program is running. The bench provokes this by raising wrEn with 0xAA at the first unlock address in the same cycle as engDone. Completion must win and the write must be lost. To judge this, the bench follows with the rest of a full identification sequence and requires cmdCode to stay 0x00, because an accepted 0xAA would have made that sequence enter identification mode.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_CMD,
    ST_PROG,
    ST_AUTO,
    ST_ER1,
    ST_ER2,
    ST_ER3,
    ST_BUSY,
    ST_CFI,
    ST_CFIAS
  } cycState_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_IDENT  = 2'd1;
  localparam logic [1:0] RM_QUERY  = 2'd2;
  localparam logic [1:0] RM_STATUS = 2'd3;

  localparam logic [7:0] CODE_NONE    = 8'h00;
  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROGRAM = 8'hA0;
  localparam logic [7:0] CODE_BYPASS  = 8'h20;
  localparam logic [7:0] CODE_QUERY   = 8'h98;
  localparam logic [7:0] CODE_ABORT   = 8'hF0;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_BYP_OUT = 8'h00;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;
    logic goProg;
    logic goChip;
    logic goSect;
  } ctlStrobe_t;

  // address matches from datapath to control
  typedef struct packed {
    logic atKeyA;
    logic atKeyB;
    logic atQuery;
  } addrHit_t;

  function automatic logic [1:0] modeOf(input logic [7:0] code);
    case (code)
      CODE_IDENT:                          modeOf = RM_IDENT;
      CODE_QUERY:                          modeOf = RM_QUERY;
      CODE_PROGRAM, CODE_CHIP, CODE_SECTOR: modeOf = RM_STATUS;
      default:                             modeOf = RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nor_cmd_datapath.sv
module nor_cmd_datapath
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_BYTES = 2,
  parameter int CMP_BITS = 11,
  parameter logic [CMP_BITS-1:0] KEY_A_ADDR = 11'h555,
  parameter logic [CMP_BITS-1:0] KEY_B_ADDR = 11'h2AA,
  parameter logic [CMP_BITS-1:0] QUERY_ADDR = 11'h055
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  ctlStrobe_t        strobe,
  output addrHit_t          hit,
  output logic              progStart,
  output logic              chipEraseStart,
  output logic              sectorEraseStart,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);

  localparam int SHIFT = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0);

  logic [CMP_BITS-1:0] cmpAddr;

  generate
    if (SHIFT == 0) begin : g_byteBus
      assign cmpAddr = wrAddr[CMP_BITS-1:0];
    end else begin : g_wideBus
      assign cmpAddr = wrAddr[CMP_BITS+SHIFT-1:SHIFT];
    end
  endgenerate

  always_comb begin
    hit.atKeyA  = (cmpAddr == KEY_A_ADDR);
    hit.atKeyB  = (cmpAddr == KEY_B_ADDR);
    hit.atQuery = (cmpAddr == QUERY_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progStart        <= 1'b0;
      chipEraseStart   <= 1'b0;
      sectorEraseStart <= 1'b0;
      opAddr           <= '0;
      opData           <= '0;
    end else begin
      progStart        <= strobe.goProg;
      chipEraseStart   <= strobe.goChip;
      sectorEraseStart <= strobe.goSect;
      if (strobe.latchOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
    end
  end

endmodule

// File: rtl/nor_cmd_control.sv
module nor_cmd_control
  import nor_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  addrHit_t   hit,
  input  logic       engDone,
  output ctlStrobe_t strobe,
  output logic [7:0] cmdCode,
  output logic [1:0] readMode
);

  cycState_e  st, stNext;
  logic [7:0] cmdNext;
  logic       bypass, bypassNext;
  logic       goReset;

  always_comb begin
    stNext     = st;
    cmdNext    = cmdCode;
    bypassNext = bypass;
    strobe     = '0;
    goReset    = 1'b0;
    if (st == ST_BUSY) begin
      // writes are dropped while an engine runs; completion wins
      if (engDone) begin
        stNext  = bypass ? ST_CMD : ST_READ;
        cmdNext = CODE_NONE;
      end
    end else if (wrEn) begin
      if (wrData == CODE_ABORT && st != ST_PROG) begin
        if (st == ST_CFIAS) begin
          stNext  = ST_AUTO;
          cmdNext = CODE_IDENT;
        end else begin
          goReset = 1'b1;
        end
      end else begin
        case (st)
          ST_READ: begin
            if (hit.atQuery && wrData == CODE_QUERY) begin
              stNext  = ST_CFI;
              cmdNext = CODE_QUERY;
            end else if (hit.atKeyA && wrData == CODE_KEY_A) begin
              stNext = ST_UNL1;
            end else begin
              goReset = 1'b1;
            end
          end
          ST_UNL1: begin
            if (hit.atKeyB && wrData == CODE_KEY_B) stNext = ST_CMD;
            else goReset = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && !hit.atKeyA) begin
              goReset = 1'b1;
            end else begin
              case (wrData)
                CODE_BYPASS: begin
                  bypassNext = 1'b1;
                  cmdNext    = CODE_NONE;
                end
                CODE_ERASE: begin
                  stNext  = ST_ER1;
                  cmdNext = CODE_ERASE;
                end
                CODE_IDENT: begin
                  stNext  = ST_AUTO;
                  cmdNext = CODE_IDENT;
                end
                CODE_PROGRAM: begin
                  stNext  = ST_PROG;
                  cmdNext = CODE_PROGRAM;
                end
                default: goReset = 1'b1;
              endcase
            end
          end
          ST_PROG: begin
            strobe.latchOp = 1'b1;
            strobe.goProg  = 1'b1;
            stNext         = ST_BUSY;
          end
          ST_AUTO: begin
            if (hit.atQuery && wrData == CODE_QUERY) begin
              stNext  = ST_CFIAS;
              cmdNext = CODE_QUERY;
            end else begin
              // bypass exit (0x00) and any other write both reset
              goReset = 1'b1;
            end
          end
          ST_ER1: begin
            if (hit.atKeyA && wrData == CODE_KEY_A) stNext = ST_ER2;
            else goReset = 1'b1;
          end
          ST_ER2: begin
            if (hit.atKeyB && wrData == CODE_KEY_B) stNext = ST_ER3;
            else goReset = 1'b1;
          end
          ST_ER3: begin
            if (wrData == CODE_CHIP && hit.atKeyA) begin
              strobe.goChip = 1'b1;
              stNext        = ST_BUSY;
              cmdNext       = CODE_CHIP;
            end else if (wrData == CODE_SECTOR) begin
              strobe.goSect  = 1'b1;
              strobe.latchOp = 1'b1;
              stNext         = ST_BUSY;
              cmdNext        = CODE_SECTOR;
            end else begin
              goReset = 1'b1;
            end
          end
          default: goReset = 1'b1;
        endcase
      end
      if (goReset) begin
        stNext     = ST_READ;
        cmdNext    = CODE_NONE;
        bypassNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_READ;
      cmdCode  <= CODE_NONE;
      readMode <= RM_ARRAY;
      bypass   <= 1'b0;
    end else begin
      st       <= stNext;
      cmdCode  <= cmdNext;
      readMode <= modeOf(cmdNext);
      bypass   <= bypassNext;
    end
  end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              engDone,
  output logic [7:0]        cmdCode,
  output logic [1:0]        readMode,
  output logic              progStart,
  output logic              chipEraseStart,
  output logic              sectorEraseStart,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);

  ctlStrobe_t strobe;
  addrHit_t   hit;

  nor_cmd_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .hit      (hit),
    .engDone  (engDone),
    .strobe   (strobe),
    .cmdCode  (cmdCode),
    .readMode (readMode)
  );

  nor_cmd_datapath #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .wrAddr           (wrAddr),
    .wrData           (wrData),
    .strobe           (strobe),
    .hit              (hit),
    .progStart        (progStart),
    .chipEraseStart   (chipEraseStart),
    .sectorEraseStart (sectorEraseStart),
    .opAddr           (opAddr),
    .opData           (opData)
  );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       engDone,
  input logic [7:0] cmdCode,
  input logic [1:0] readMode,
  input logic       progStart,
  input logic       chipEraseStart,
  input logic       sectorEraseStart
);

  a_r4_ident_mode: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 8'h90) |-> (readMode == 2'd1));

  a_r8_query_mode: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 8'h98) |-> (readMode == 2'd2));

  a_r5_one_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, chipEraseStart, sectorEraseStart}));

  a_r4_prog_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> $past(wrEn));

  a_r5_chip_cmd: assert property (@(posedge clk) disable iff (!rstN)
    chipEraseStart |-> (cmdCode == 8'h10 && readMode == 2'd3));

  a_r6_erase_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == 8'h10 || cmdCode == 8'h30) && !engDone) |=> $stable(cmdCode));

  a_r6_done_exits: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdCode == 8'h10 || cmdCode == 8'h30) && engDone) |=> (cmdCode == 8'h00));

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (.*);

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        engDone = 1'b0;
  logic [7:0]  cmdCode;
  logic [1:0]  readMode;
  logic        progStart, chipEraseStart, sectorEraseStart;
  logic [15:0] opAddr;
  logic [7:0]  opData;

  int applied = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(16), .BUS_BYTES(2)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .engDone(engDone), .cmdCode(cmdCode), .readMode(readMode),
    .progStart(progStart), .chipEraseStart(chipEraseStart),
    .sectorEraseStart(sectorEraseStart), .opAddr(opAddr), .opData(opData)
  );

  // byte offsets on a 16-bit bus: word 0x555 -> 0x0AAA, 0x2AA -> 0x0554, 0x55 -> 0x00AA
  typedef struct packed {
    logic        done;
    logic [15:0] a;
    logic [7:0]  d;
    logic [7:0]  c;
    logic [1:0]  m;
    logic [2:0]  p;   // {prog, chip, sector}
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd2},   // R2
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd2},
    '{1'b0, 16'h0AAA, 8'h90, 8'h90, 2'd1, 3'b000, 4'd4},   // R4 ident
    '{1'b0, 16'h0000, 8'hF0, 8'h00, 2'd0, 3'b000, 4'd10},  // R10 abort
    '{1'b0, 16'h1AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd3},   // R3 aliases
    '{1'b0, 16'h1554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd3},
    '{1'b0, 16'h1AAA, 8'h90, 8'h90, 2'd1, 3'b000, 4'd3},
    '{1'b0, 16'h00AA, 8'h98, 8'h98, 2'd2, 3'b000, 4'd9},   // R9 query sub-mode
    '{1'b0, 16'h0000, 8'hF0, 8'h90, 2'd1, 3'b000, 4'd9},
    '{1'b0, 16'h0000, 8'h12, 8'h00, 2'd0, 3'b000, 4'd9},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd4},   // R4 program
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd4},
    '{1'b0, 16'h0AAA, 8'hA0, 8'hA0, 2'd3, 3'b000, 4'd4},
    '{1'b0, 16'h0100, 8'hF0, 8'hA0, 2'd3, 3'b100, 4'd10},  // R10 F0 as data
    '{1'b0, 16'h0000, 8'hF0, 8'hA0, 2'd3, 3'b000, 4'd6},   // R6 ignored
    '{1'b1, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd6},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd2},   // R2 bad key
    '{1'b0, 16'h0554, 8'h56, 8'h00, 2'd0, 3'b000, 4'd2},
    '{1'b0, 16'h0AAA, 8'h90, 8'h00, 2'd0, 3'b000, 4'd2},
    '{1'b0, 16'h00AA, 8'h98, 8'h98, 2'd2, 3'b000, 4'd8},   // R8 query
    '{1'b0, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd8},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd5},   // R5 sector
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'h80, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0554, 8'h55, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h4000, 8'h30, 8'h30, 2'd3, 3'b001, 4'd5},
    '{1'b0, 16'h0000, 8'hF0, 8'h30, 2'd3, 3'b000, 4'd6},
    '{1'b1, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd6},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd5},   // R5 chip
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'h80, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0554, 8'h55, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'h10, 8'h10, 2'd3, 3'b010, 4'd5},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h10, 2'd3, 3'b000, 4'd6},
    '{1'b1, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd6},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd5},   // R5 chip wrong addr
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'h80, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0554, 8'h55, 8'h80, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0100, 8'h10, 8'h00, 2'd0, 3'b000, 4'd5},
    '{1'b0, 16'h0AAA, 8'hAA, 8'h00, 2'd0, 3'b000, 4'd7},   // R7 bypass
    '{1'b0, 16'h0554, 8'h55, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h0AAA, 8'h20, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h0200, 8'hA0, 8'hA0, 2'd3, 3'b000, 4'd7},
    '{1'b0, 16'h0300, 8'h33, 8'hA0, 2'd3, 3'b100, 4'd7},
    '{1'b1, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h0010, 8'hA0, 8'hA0, 2'd3, 3'b000, 4'd7},
    '{1'b0, 16'h0020, 8'h44, 8'hA0, 2'd3, 3'b100, 4'd7},
    '{1'b1, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h0000, 8'h90, 8'h90, 2'd1, 3'b000, 4'd7},
    '{1'b0, 16'h0000, 8'h00, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h0010, 8'hA0, 8'h00, 2'd0, 3'b000, 4'd7},
    '{1'b0, 16'h00AC, 8'h98, 8'h00, 2'd0, 3'b000, 4'd8}    // R8 wrong address
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic checkOut(input string req, input logic [7:0] c, input logic [1:0] m,
                          input logic [2:0] p);
    chk(req, "cmdCode", 32'(cmdCode), 32'(c));
    chk(req, "readMode", 32'(readMode), 32'(m));
    chk(req, "starts", 32'({progStart, chipEraseStart, sectorEraseStart}), 32'(p));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1", 8'h00, 2'd0, 3'b000);   // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", 8'h00, 2'd0, 3'b000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].done) done();
      else wr(VEC[i].a, VEC[i].d);
      checkOut($sformatf("R%0d", VEC[i].r), VEC[i].c, VEC[i].m, VEC[i].p);
    end

    // R4: program latches address and data
    wr(16'h0AAA, 8'hAA); wr(16'h0554, 8'h55); wr(16'h0AAA, 8'hA0);
    wr(16'h0246, 8'h5A);
    chk("R4", "opAddr", 32'(opAddr), 32'h0246);
    chk("R4", "opData", 32'(opData), 32'h5A);
    chk("R4", "progStart", 32'(progStart), 32'd1);
    @(negedge clk);
    chk("R4", "progStart width", 32'(progStart), 32'd0);

    // R11: write coincident with completion is dropped
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'h0AAA; wrData = 8'hAA; engDone = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; engDone = 1'b0;
    chk("R11", "cmdCode", 32'(cmdCode), 32'h00);
    wr(16'h0554, 8'h55); wr(16'h0AAA, 8'h90);
    chk("R11", "cmdCode after rest of sequence", 32'(cmdCode), 32'h00);

    // R5: sector erase address latched
    wr(16'h0AAA, 8'hAA); wr(16'h0554, 8'h55); wr(16'h0AAA, 8'h80);
    wr(16'h0AAA, 8'hAA); wr(16'h0554, 8'h55); wr(16'h3C00, 8'h30);
    chk("R5", "opAddr", 32'(opAddr), 32'h3C00);
    done();

    // R1: reset clears bypass
    wr(16'h0AAA, 8'hAA); wr(16'h0554, 8'h55); wr(16'h0AAA, 8'h20);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    checkOut("R1", 8'h00, 2'd0, 3'b000);
    rstN = 1'b1;
    wr(16'h0010, 8'hA0);
    chk("R1", "bypass cleared", 32'(cmdCode), 32'h00);

    summary();
    $finish;
  end

endmodule